// File: doc/BRIEF.md
# VLAN Membership Table with Command Engine

This block keeps the per-VLAN membership table of a small Ethernet switch. Each of the DEPTH slots holds a valid flag, a 13-bit VLAN identifier, an 8-bit forwarding database number and, for every port, a 2-bit membership code and a 2-bit port state. A host programs and inspects the table through a 16-bit register port. It stages an entry in the VID and data registers, then writes the command register with the busy bit set.

Three commands are supported. Load/Purge inserts, overwrites or removes the entry for the staged VID. Get-Next finds the next higher valid VID and copies its entry back into the registers. Flush clears the whole table. Each command walks the slots one per cycle with a single table access per cycle. While a command runs, every host write is dropped.

The controller has six states. IDLE goes to FLUSH, LD_SCAN or NX_SCAN when a valid command is started. FLUSH clears one slot per cycle and goes back to IDLE after the last slot. LD_SCAN looks for a matching slot and a free slot, then goes to LD_COMMIT, which makes at most one write and returns to IDLE. NX_SCAN tracks the best candidate and goes to NX_DONE, which updates the host registers and returns to IDLE.

Top module: `vlan_tbl_unit`

## Requirements
- R1: A write to address 0 with bit 15 set and opcode bits 14:12 equal to 1 (flush), 2 (load/purge) or 3 (get-next) sets busy (bit 15 of address 0) from the next cycle. Busy then stays high for exactly DEPTH cycles for flush and DEPTH+1 cycles for the other two commands.
- R2: Address 1 is the VID register: bits 11:0 hold VID bits 11:0, bit 12 is the valid flag and bit 13 is VID bit 12. Addresses 2 and up are the data registers. After reset every register reads zero and the table is empty.
- R3: Get-Next returns the smallest stored valid VID that is strictly greater than the VID register value. It writes that VID into the VID register with the valid flag set.
- R4: When Get-Next finds no greater VID, the VID register becomes 0x1FFF with the valid flag clear.
- R5: A successful Get-Next copies the entry's port fields into the data registers. Port n sits in data register n/4 at bit (n mod 4)*4: bits 1:0 of that nibble are the membership code and bits 3:2 are the port state.
- R6: The database number sits in the command register, with bits 3:0 at bits 3:0 and bits 7:4 at bits 11:8. It is taken from the command write for a load and replaced by the found entry's value after a successful Get-Next.
- R7: Load with the valid flag set stores the VID, the data registers and the database number. If the VID is already present, its slot is overwritten, even when the table is full.
- R8: Load with the valid flag clear removes the entry for that VID. Purging an absent VID changes nothing.
- R9: Flush invalidates every slot.
- R10: Loading a new VID into a full table leaves the table unchanged and sets bit 7 of the command register. That bit stays set until reset.
- R11: Any register write made while busy is set has no effect, including a new command.
- R12: Repeating Get-Next without rewriting the VID register walks the valid VIDs in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |

## Verification
The write that starts a command is sampled at edge E0, and busy reads high from the falling edge after E0. A flush finishes at edge E_DEPTH. A load commits its table write at E_DEPTH+1, and a Get-Next updates the VID, data and command registers at that same edge, which is also where busy falls. The bench counts falling edges with busy high and compares the count with DEPTH or DEPTH+1. It reads results only after busy has cleared, so every compare sees settled registers. Dropped writes are issued in the cycles right after a start, well inside the busy window, and then checked by reading back the registers and walking the table.

// File: rtl/vlan_tbl_pkg.sv
package vlan_tbl_pkg;
    localparam int VID_W = 13;
    localparam int FID_W = 8;
    localparam int REG_W = 16;

    localparam logic [2:0] OPC_FLUSH = 3'd1;
    localparam logic [2:0] OPC_LOAD  = 3'd2;
    localparam logic [2:0] OPC_NEXT  = 3'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FLUSH,
        S_LD_SCAN,
        S_LD_COMMIT,
        S_NX_SCAN,
        S_NX_DONE
    } state_e;
endpackage

// File: rtl/vlan_tbl_store.sv
module vlan_tbl_store
    import vlan_tbl_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int PW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             wclr,
    input  logic [IDX_W-1:0] widx,
    input  logic [VID_W-1:0] wvid,
    input  logic [FID_W-1:0] wfid,
    input  logic [PW-1:0]    wports,
    input  logic [IDX_W-1:0] ridx,
    output logic             rvalid,
    output logic [VID_W-1:0] rvid,
    output logic [FID_W-1:0] rfid,
    output logic [PW-1:0]    rports
);
    logic [DEPTH-1:0] val_q;
    logic [VID_W-1:0] vid_q  [DEPTH];
    logic [FID_W-1:0] fid_q  [DEPTH];
    logic [PW-1:0]    port_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                vid_q[i]  <= '0;
                fid_q[i]  <= '0;
                port_q[i] <= '0;
            end
        end else if (we) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (widx == IDX_W'(i)) begin
                    val_q[i] <= !wclr;
                    if (!wclr) begin
                        vid_q[i]  <= wvid;
                        fid_q[i]  <= wfid;
                        port_q[i] <= wports;
                    end
                end
            end
        end
    end

    assign rvalid = val_q[ridx];
    assign rvid   = vid_q[ridx];
    assign rfid   = fid_q[ridx];
    assign rports = port_q[ridx];
endmodule

// File: rtl/vlan_tbl_ctrl.sv
module vlan_tbl_ctrl
    import vlan_tbl_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int PW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       opc,
    input  logic [VID_W-1:0] key_vid,
    input  logic             key_vld,
    input  logic             rvalid,
    input  logic [VID_W-1:0] rvid,
    input  logic [FID_W-1:0] rfid,
    input  logic [PW-1:0]    rports,
    output logic             busy,
    output logic [IDX_W-1:0] ridx,
    output logic             mem_we,
    output logic             mem_wclr,
    output logic [IDX_W-1:0] mem_widx,
    output logic             full_set,
    output logic             nx_done,
    output logic             nx_found,
    output logic [VID_W-1:0] nx_vid,
    output logic [FID_W-1:0] nx_fid,
    output logic [PW-1:0]    nx_ports
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, hit_idx_q, free_idx_q;
    logic             hit_q, free_q, best_q;
    logic [VID_W-1:0] bvid_q;
    logic [FID_W-1:0] bfid_q;
    logic [PW-1:0]    bports_q;
    logic             last;

    assign last = (idx_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    case (opc)
                        OPC_FLUSH: state_d = S_FLUSH;
                        OPC_LOAD:  state_d = S_LD_SCAN;
                        OPC_NEXT:  state_d = S_NX_SCAN;
                        default:   state_d = S_IDLE;
                    endcase
                end
            end
            S_FLUSH:     if (last) state_d = S_IDLE;
            S_LD_SCAN:   if (last) state_d = S_LD_COMMIT;
            S_LD_COMMIT: state_d = S_IDLE;
            S_NX_SCAN:   if (last) state_d = S_NX_DONE;
            S_NX_DONE:   state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // scan datapath: slot index, match/free slot, best Get-Next candidate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0; hit_idx_q <= '0; free_idx_q <= '0;
            hit_q <= 1'b0; free_q <= 1'b0; best_q <= 1'b0;
            bvid_q <= '0; bfid_q <= '0; bports_q <= '0;
        end else if (state_q == S_IDLE) begin
            idx_q <= '0; hit_q <= 1'b0; free_q <= 1'b0; best_q <= 1'b0;
        end else begin
            if (state_q == S_FLUSH || state_q == S_LD_SCAN || state_q == S_NX_SCAN)
                idx_q <= idx_q + 1'b1;
            if (state_q == S_LD_SCAN) begin
                if (rvalid && rvid == key_vid) begin
                    hit_q <= 1'b1; hit_idx_q <= idx_q;
                end
                if (!rvalid && !free_q) begin
                    free_q <= 1'b1; free_idx_q <= idx_q;
                end
            end
            if (state_q == S_NX_SCAN && rvalid && rvid > key_vid &&
                (!best_q || rvid < bvid_q)) begin
                best_q <= 1'b1; bvid_q <= rvid; bfid_q <= rfid; bports_q <= rports;
            end
        end
    end

    always_comb begin
        busy     = (state_q != S_IDLE);
        ridx     = idx_q;
        mem_we   = 1'b0;
        mem_wclr = 1'b0;
        mem_widx = hit_q ? hit_idx_q : free_idx_q;
        full_set = 1'b0;
        nx_done  = (state_q == S_NX_DONE);
        nx_found = best_q;
        nx_vid   = bvid_q;
        nx_fid   = bfid_q;
        nx_ports = bports_q;
        unique case (state_q)
            S_FLUSH: begin
                mem_we = 1'b1; mem_wclr = 1'b1; mem_widx = idx_q;
            end
            S_LD_COMMIT: begin
                if (key_vld) begin
                    mem_we   = hit_q || free_q;
                    full_set = !hit_q && !free_q;
                end else begin
                    mem_we   = hit_q;
                    mem_wclr = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vlan_tbl_unit.sv
module vlan_tbl_unit
    import vlan_tbl_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int DEPTH     = 8,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam int DATA_REGS = (NUM_PORTS + 3) / 4;
    localparam int PW        = DATA_REGS * REG_W;
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] PMASK = {PW{1'b1}} >> (PW - NUM_PORTS * 4);

    logic [2:0]       opc_q;
    logic [FID_W-1:0] fid_q;
    logic             full_q;
    logic [VID_W-1:0] vid_q;
    logic             vld_q;
    logic [PW-1:0]    data_q;

    logic             busy, start, wr_ok;
    logic [IDX_W-1:0] ridx, mem_widx;
    logic             mem_we, mem_wclr, full_set;
    logic             rvalid, nx_done, nx_found;
    logic [VID_W-1:0] rvid, nx_vid;
    logic [FID_W-1:0] rfid, nx_fid;
    logic [PW-1:0]    rports, nx_ports;
    logic [2:0]       w_opc;

    assign wr_ok = reg_wr && !busy;
    assign w_opc = reg_wdata[14:12];
    assign start = wr_ok && (reg_addr == '0) && reg_wdata[15] &&
                   (w_opc == OPC_FLUSH || w_opc == OPC_LOAD || w_opc == OPC_NEXT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q <= '0; fid_q <= '0; full_q <= 1'b0;
            vid_q <= '0; vld_q <= 1'b0; data_q <= '0;
        end else begin
            if (wr_ok) begin
                if (reg_addr == ADDR_W'(0)) begin
                    opc_q <= w_opc;
                    fid_q <= {reg_wdata[11:8], reg_wdata[3:0]};
                end
                if (reg_addr == ADDR_W'(1)) begin
                    vid_q <= {reg_wdata[13], reg_wdata[11:0]};
                    vld_q <= reg_wdata[12];
                end
                for (int k = 0; k < DATA_REGS; k++)
                    if (reg_addr == ADDR_W'(k + 2))
                        data_q[k*REG_W +: REG_W] <= reg_wdata;
            end
            if (nx_done) begin
                if (nx_found) begin
                    vid_q <= nx_vid; vld_q <= 1'b1;
                    fid_q <= nx_fid; data_q <= nx_ports;
                end else begin
                    vid_q <= '1; vld_q <= 1'b0;
                end
            end
            if (full_set) full_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(0))
            reg_rdata = {busy, opc_q, fid_q[7:4], full_q, 3'b000, fid_q[3:0]};
        else if (reg_addr == ADDR_W'(1))
            reg_rdata = {2'b00, vid_q[12], vld_q, vid_q[11:0]};
        for (int k = 0; k < DATA_REGS; k++)
            if (reg_addr == ADDR_W'(k + 2))
                reg_rdata = data_q[k*REG_W +: REG_W];
    end

    vlan_tbl_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PW(PW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .opc(w_opc),
        .key_vid(vid_q), .key_vld(vld_q),
        .rvalid(rvalid), .rvid(rvid), .rfid(rfid), .rports(rports),
        .busy(busy), .ridx(ridx), .mem_we(mem_we), .mem_wclr(mem_wclr),
        .mem_widx(mem_widx), .full_set(full_set), .nx_done(nx_done),
        .nx_found(nx_found), .nx_vid(nx_vid), .nx_fid(nx_fid), .nx_ports(nx_ports)
    );

    vlan_tbl_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PW(PW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .wclr(mem_wclr), .widx(mem_widx),
        .wvid(vid_q), .wfid(fid_q), .wports(data_q & PMASK),
        .ridx(ridx), .rvalid(rvalid), .rvid(rvid), .rfid(rfid), .rports(rports)
    );
endmodule

// File: rtl/vlan_tbl_chk.sv
module vlan_tbl_chk
    import vlan_tbl_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             reg_wr,
    input logic             start,
    input logic [2:0]       opc_q,
    input logic [FID_W-1:0] fid_q,
    input logic             full_q,
    input logic [VID_W-1:0] vid_q,
    input logic             vld_q,
    input logic             nx_done,
    input logic             nx_found
);
    localparam logic [15:0] D16 = 16'(DEPTH);
    logic [15:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (busy) cnt <= cnt + 16'd1;
        else           cnt <= '0;
    end

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    p_flush_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && opc_q == OPC_FLUSH) |-> cnt == D16);
    p_cmd_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && opc_q != OPC_FLUSH) |-> cnt == D16 + 16'd1);
    p_walk_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nx_done && nx_found) |=> (vld_q && vid_q > $past(vid_q)));
    p_end_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nx_done && !nx_found) |=> (vid_q == 13'h1FFF && !vld_q));
    p_full_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |=> full_q);
    p_wr_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && !nx_done) |=> ($stable(opc_q) && $stable(fid_q)));
endmodule

bind vlan_tbl_unit vlan_tbl_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .reg_wr(reg_wr), .start(start),
    .opc_q(opc_q), .fid_q(fid_q), .full_q(full_q), .vid_q(vid_q),
    .vld_q(vld_q), .nx_done(nx_done), .nx_found(nx_found)
);

// File: tb/vlan_tbl_unit_tb.sv
`timescale 1ns/1ps
module vlan_tbl_unit_tb_top;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] rv;

    always #5 clk = ~clk;

    vlan_tbl_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [15:0] vraw(input logic [12:0] v, input logic ok);
        return {2'b00, v[12], ok, v[11:0]};
    endfunction

    function automatic logic [15:0] oraw(input logic [2:0] op, input logic [7:0] f,
                                         input logic full);
        return {1'b0, op, f[7:4], full, 3'b000, f[3:0]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        rd(0, rv);
        while (rv[15] && n < 1000) begin
            n++;
            @(negedge clk);
            rd(0, rv);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [7:0] f, input int exp_len);
        int n;
        wr(0, {1'b1, op, f[7:4], 4'h0, f[3:0]});
        wait_idle(n);
        chk("R1 busy length", 16'(n), 16'(exp_len));
    endtask

    task automatic load(input logic [12:0] v, input logic ok, input logic [7:0] f,
                        input logic [15:0] d0, input logic [15:0] d1);
        wr(1, vraw(v, ok));
        wr(2, d0);
        wr(3, d1);
        cmd(3'd2, f, D + 1);
    endtask

    task automatic next_from(input logic [12:0] key);
        wr(1, vraw(key, 1'b0));
        cmd(3'd3, 8'h00, D + 1);
    endtask

    task automatic expect_entry(input string tag, input logic [12:0] v, input logic [7:0] f,
                                input logic [15:0] d0, input logic [15:0] d1,
                                input logic full);
        rd(1, rv); chk({tag, " R3 vid"}, rv, vraw(v, 1'b1));
        rd(2, rv); chk({tag, " R5 data0"}, rv, d0);
        rd(3, rv); chk({tag, " R5 data1"}, rv, d1);
        rd(0, rv); chk({tag, " R6 db number"}, rv, oraw(3'd3, f, full));
    endtask

    task automatic t_reset();
        rd(0, rv); chk("R2 reset op", rv, 16'h0000);
        rd(1, rv); chk("R2 reset vid", rv, 16'h0000);
        rd(2, rv); chk("R2 reset data0", rv, 16'h0000);
        next_from(13'h0);
        rd(1, rv); chk("R2 empty after reset", rv, 16'h2FFF);
    endtask

    task automatic t_walk();
        load(13'h100, 1'b1, 8'hA5, 16'h4321, 16'h8765);
        load(13'h1005, 1'b1, 8'h3C, 16'h00F0, 16'h0F00);
        load(13'h050, 1'b1, 8'h12, 16'hC0DE, 16'h0B0E);
        next_from(13'h000);
        expect_entry("walk1", 13'h050, 8'h12, 16'hC0DE, 16'h0B0E, 1'b0);
        cmd(3'd3, 8'h00, D + 1);   // R12: continue without rewriting VID
        expect_entry("R12 walk2", 13'h100, 8'hA5, 16'h4321, 16'h8765, 1'b0);
        cmd(3'd3, 8'h00, D + 1);
        expect_entry("R12 walk3 page", 13'h1005, 8'h3C, 16'h00F0, 16'h0F00, 1'b0);
        cmd(3'd3, 8'h00, D + 1);
        rd(1, rv); chk("R4 end marker", rv, 16'h2FFF);
    endtask

    task automatic t_overwrite();
        load(13'h100, 1'b1, 8'h11, 16'hAAAA, 16'h5555);
        next_from(13'h0FF);
        expect_entry("R7 overwrite", 13'h100, 8'h11, 16'hAAAA, 16'h5555, 1'b0);
    endtask

    task automatic t_purge();
        load(13'h100, 1'b0, 8'h00, 16'h0, 16'h0);
        next_from(13'h050);
        rd(1, rv); chk("R8 purge removed", rv, vraw(13'h1005, 1'b1));
        load(13'h777, 1'b0, 8'h00, 16'h0, 16'h0);
        next_from(13'h000);
        rd(1, rv); chk("R8 absent purge no change", rv, vraw(13'h050, 1'b1));
    endtask

    task automatic t_ignore();
        int n;
        wr(1, vraw(13'h050, 1'b0));
        wr(0, 16'hB000);          // start get-next
        wr(1, 16'h0123);          // dropped while busy
        wr(2, 16'hFFFF);          // dropped
        wr(0, 16'h9000);          // flush start dropped
        wait_idle(n);
        rd(1, rv); chk("R11 vid write dropped", rv, vraw(13'h1005, 1'b1));
        rd(2, rv); chk("R11 data write dropped", rv, 16'h00F0);
        rd(0, rv); chk("R11 op write dropped", rv, oraw(3'd3, 8'h3C, 1'b0));
        next_from(13'h000);
        rd(1, rv); chk("R11 flush did not run", rv, vraw(13'h050, 1'b1));
    endtask

    task automatic t_flush();
        cmd(3'd1, 8'h00, D);
        next_from(13'h000);
        rd(1, rv); chk("R9 table empty after flush", rv, 16'h2FFF);
    endtask

    task automatic t_full();
        for (int i = 1; i <= D; i++)
            load(13'(i * 10), 1'b1, 8'(i), 16'(i), 16'h0);
        rd(0, rv); chk("R10 no violation yet", {15'h0, rv[7]}, 16'h0);
        load(13'd15, 1'b1, 8'h99, 16'h1, 16'h1);
        rd(0, rv); chk("R10 violation bit", {15'h0, rv[7]}, 16'h1);
        next_from(13'd10);
        rd(1, rv); chk("R10 new vid not stored", rv, vraw(13'd20, 1'b1));
        load(13'd30, 1'b1, 8'h77, 16'hBEEF, 16'h0);
        next_from(13'd29);
        expect_entry("R7 overwrite when full", 13'd30, 8'h77, 16'hBEEF, 16'h0, 1'b1);
        rd(0, rv); chk("R10 violation sticky", {15'h0, rv[7]}, 16'h1);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_walk();
        t_overwrite();
        t_purge();
        t_ignore();
        t_flush();
        t_full();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule